// File: doc/BRIEF.md
# Multi-Rail Power-Up Sequencer

This block is the digital timing core that brings up the rails of a display-panel power IC in a set order. It controls seven rails: the main source-driver boost, the gate-high boost, the gate-low charge pump, the core buck, the I/O buck, the linear regulator and the common-electrode amplifier. For each rail it drives an enable and a soft-start-active strobe. Timing comes from a one-millisecond tick input, plus delay and soft-start codes that arrive as static configuration pins. A global flag goes high once every enabled rail is up.

Each rail starts its delay from its own trigger, so the rails form a dependency chain. Three events can serve as a trigger: the start of a run, the start of the main boost's ramp, and the main boost becoming ready. Every rail has its own down-counter, so several delays can run at once. A run is active while the under-voltage-lockout-ok flag and the enable are both high. When either one drops, every output goes low in the same cycle and every timer returns to idle. The next rise of both flags starts a fresh run. There is no data stream here, so every pin is a plain level or a single-cycle tick with no handshake.

Top module: `power_seq_ctrl`

## Requirements
- R1: Reset behaviour. While reset is asserted, and afterwards until a run starts, `rail_en`, `rail_ss` and `seq_done` are all zero. Bit order in every rail vector: 0 main boost, 1 gate-high, 2 gate-low, 3 core buck, 4 I/O buck, 5 linear regulator, 6 common amplifier.
- R2: Run start.
  - A run is active while `uvlo_ok` and `en` are both high. Nothing starts while only one of them is high.
  - The start event is the first clock edge at which both are high. From then on, time T counts the `tick_ms` pulses seen at later clock edges.
- R3: Main boost timing.
  - The ramp begins at T = 5·`src_dly_code`.
  - The soft-start window then lasts 5·(`src_ss_code`+1) ticks. During it `rail_ss` and `rail_en` are both high.
  - When the window ends, the rail is ready: `rail_en` stays high and `rail_ss` goes low.
- R4: Core buck, I/O buck and linear regulator timing.
  - Each ramp begins at T = 3·code, counted from the start event.
  - Each soft-start window is FIXED_SS_MS ticks long (default 1).
- R5: Gate-low timing.
  - The ramp begins 5·`gl_dly_code` ticks after the main boost's ramp begins.
  - The soft-start window is 2·(`gl_ss_code`+1) ticks.
- R6: Common-amplifier timing.
  - The ramp begins 5·`com_dly_code` ticks after the main boost's ramp begins.
  - The soft-start window is FIXED_SS_MS ticks.
- R7: Gate-high timing.
  - The ramp begins 5·`gh_dly_code` ticks after the main boost becomes ready.
  - The soft-start window is 2·(`gh_ss_code`+1) ticks.
- R8: Zero delay. A delay code of zero starts the ramp at the same clock edge as the rail's trigger. A tick at that same edge is not counted toward the rail's windows.
- R9: Stop.
  - When `uvlo_ok` or `en` drops, all bits of `rail_en` and `rail_ss`, and `seq_done`, go to zero in that same cycle.
  - The timers are cleared, so a later run repeats the whole sequence from T = 0.
- R10: Disabled rails. A rail whose `rail_mask` bit is 0 never raises its `rail_en` or `rail_ss` bit. Its timing still runs and still paces the rails that depend on it.
- R11: Done flag.
  - `seq_done` is high while a run is active and every enabled rail has finished its soft-start window with its `rail_ready` bit high.
  - Disabled rails are ignored.
  - `seq_done` falls as soon as any enabled rail's ready bit goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_ms | input | 1 | One-cycle pulse every millisecond |
| uvlo_ok | input | 1 | Input supply is above the lockout threshold |
| en | input | 1 | Global enable |
| rail_mask | input | 7 | Per-rail enable selection |
| rail_ready | input | 7 | Per-rail ready flags from the converters |
| src_dly_code | input | 3 | Main boost start delay, 5 ms steps |
| src_ss_code | input | 2 | Main boost soft-start, 5 ms steps from 5 ms |
| gh_dly_code | input | 3 | Gate-high start delay, 5 ms steps |
| gh_ss_code | input | 2 | Gate-high soft-start, 2 ms steps from 2 ms |
| gl_dly_code | input | 3 | Gate-low start delay, 5 ms steps |
| gl_ss_code | input | 2 | Gate-low soft-start, 2 ms steps from 2 ms |
| core_dly_code | input | 2 | Core buck start delay, 3 ms steps |
| io_dly_code | input | 2 | I/O buck start delay, 3 ms steps |
| lin_dly_code | input | 2 | Linear regulator start delay, 3 ms steps |
| com_dly_code | input | 5 | Common amplifier start delay, 5 ms steps |
| rail_en | output | 7 | Per-rail enables |
| rail_ss | output | 7 | Per-rail soft-start-active strobes |
| seq_done | output | 1 | All enabled rails are up |

## Verification
The assertions check the ordering of the chain on every cycle:
- Gate-high never starts before the main boost is ready.
- Gate-low and the common amplifier never start before the main boost has begun its ramp.
- Each timer is idle in the cycle after a stop, and a ready rail stays ready for the rest of its run.
- Every start or ready pulse lands in the matching state.
- Whenever the done flag is high, every enabled rail is enabled and none is still ramping.

Only the bench's scenarios can show the exact tick counts of each delay and window, which they check across default, maximum, zero and mixed codes. They also cover the masked main boost still pacing its dependants, a stop in mid-sequence followed by a full restart, and a held-low ready flag keeping the done flag down.

// File: rtl/pwrseq_pkg.sv
package pwrseq_pkg;

  localparam int NRAIL     = 7;
  localparam int RAIL_SRC  = 0;
  localparam int RAIL_GH   = 1;
  localparam int RAIL_GL   = 2;
  localparam int RAIL_CORE = 3;
  localparam int RAIL_IO   = 4;
  localparam int RAIL_LIN  = 5;
  localparam int RAIL_COM  = 6;

  typedef enum logic [1:0] {
    RT_IDLE = 2'd0,
    RT_WAIT = 2'd1,
    RT_RAMP = 2'd2,
    RT_ON   = 2'd3
  } rail_st_e;

  typedef enum logic [1:0] {
    TRG_GO        = 2'd0,
    TRG_SRC_RAMP  = 2'd1,
    TRG_SRC_READY = 2'd2
  } trig_src_e;

  // Which event starts a rail's delay count
  function automatic trig_src_e trig_of(input int idx);
    case (idx)
      RAIL_GH:           return TRG_SRC_READY;
      RAIL_GL, RAIL_COM: return TRG_SRC_RAMP;
      default:           return TRG_GO;
    endcase
  endfunction

endpackage

// File: rtl/pwrseq_rail_timer.sv
module pwrseq_rail_timer
  import pwrseq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             trig,
  input  logic             tick,
  input  logic [CNT_W-1:0] dly_ms,
  input  logic [CNT_W-1:0] ss_ms,
  output logic             ramp_o,
  output logic             on_o,
  output logic             start_p,
  output logic             ready_p
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  rail_st_e         st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!run) begin
      st_d  = RT_IDLE;
      cnt_d = '0;
    end else begin
      case (st_q)
        RT_IDLE: begin
          if (trig) begin
            if (dly_ms == '0) begin
              st_d  = RT_RAMP;
              cnt_d = ss_ms;
            end else begin
              st_d  = RT_WAIT;
              cnt_d = dly_ms;
            end
          end
        end
        RT_WAIT: begin
          if (tick) begin
            if (cnt_q <= ONE) begin
              st_d  = RT_RAMP;
              cnt_d = ss_ms;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        RT_RAMP: begin
          if (tick) begin
            if (cnt_q <= ONE) begin
              st_d  = RT_ON;
              cnt_d = '0;
            end else begin
              cnt_d = cnt_q - ONE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= RT_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign ramp_o  = (st_q == RT_RAMP);
  assign on_o    = (st_q == RT_ON);
  assign start_p = (st_d == RT_RAMP) && (st_q != RT_RAMP);
  assign ready_p = (st_d == RT_ON) && (st_q != RT_ON);

  // R9: a stop clears the timer by the next cycle
  p_idle_after_stop_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (st_q == RT_IDLE));

  // R11: a ready rail stays ready while the run lasts
  p_on_holds_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RT_ON && run) |=> (st_q == RT_ON));

endmodule

// File: rtl/pwrseq_start_det.sv
module pwrseq_start_det (
  input  logic clk,
  input  logic rst_n,
  input  logic uvlo_ok,
  input  logic en,
  output logic run,
  output logic go,
  output logic started
);

  logic run_q;

  assign run = uvlo_ok & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run;
  end

  assign go      = run & ~run_q;
  assign started = run & run_q;

  // R2: the start event is a single-cycle pulse
  p_go_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !go);

endmodule

// File: rtl/pwrseq_done_mon.sv
module pwrseq_done_mon #(
  parameter int N = 7
) (
  input  logic         started,
  input  logic [N-1:0] on_vec,
  input  logic [N-1:0] ready_in,
  input  logic [N-1:0] mask,
  output logic         done
);

  logic [N-1:0] rail_fin;

  for (genvar i = 0; i < N; i++) begin : g_fin
    assign rail_fin[i] = ~mask[i] | (on_vec[i] & ready_in[i]);
  end

  assign done = started & (&rail_fin);

endmodule

// File: rtl/power_seq_ctrl.sv
module power_seq_ctrl
  import pwrseq_pkg::*;
#(
  parameter int CNT_W         = 8,
  parameter int LDLY_W        = 3,
  parameter int BDLY_W        = 2,
  parameter int CDLY_W        = 5,
  parameter int SS_W          = 2,
  parameter int STEP_LONG_MS  = 5,
  parameter int STEP_BUCK_MS  = 3,
  parameter int STEP_SRCSS_MS = 5,
  parameter int STEP_GATESS_MS= 2,
  parameter int FIXED_SS_MS   = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_ms,
  input  logic              uvlo_ok,
  input  logic              en,
  input  logic [NRAIL-1:0]  rail_mask,
  input  logic [NRAIL-1:0]  rail_ready,
  input  logic [LDLY_W-1:0] src_dly_code,
  input  logic [SS_W-1:0]   src_ss_code,
  input  logic [LDLY_W-1:0] gh_dly_code,
  input  logic [SS_W-1:0]   gh_ss_code,
  input  logic [LDLY_W-1:0] gl_dly_code,
  input  logic [SS_W-1:0]   gl_ss_code,
  input  logic [BDLY_W-1:0] core_dly_code,
  input  logic [BDLY_W-1:0] io_dly_code,
  input  logic [BDLY_W-1:0] lin_dly_code,
  input  logic [CDLY_W-1:0] com_dly_code,
  output logic [NRAIL-1:0]  rail_en,
  output logic [NRAIL-1:0]  rail_ss,
  output logic              seq_done
);

  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);
  localparam logic [CNT_W-1:0] K_LONG  = CNT_W'(STEP_LONG_MS);
  localparam logic [CNT_W-1:0] K_BUCK  = CNT_W'(STEP_BUCK_MS);
  localparam logic [CNT_W-1:0] K_SRCSS = CNT_W'(STEP_SRCSS_MS);
  localparam logic [CNT_W-1:0] K_GATSS = CNT_W'(STEP_GATESS_MS);
  localparam logic [CNT_W-1:0] K_FIXSS = CNT_W'(FIXED_SS_MS);

  logic run, go, started;
  logic src_start, src_ready;
  logic [NRAIL-1:0] ramp_vec, on_vec, start_vec, ready_vec;
  logic [CNT_W-1:0] dly_ms [NRAIL];
  logic [CNT_W-1:0] ss_ms  [NRAIL];

  pwrseq_start_det u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .uvlo_ok (uvlo_ok),
    .en      (en),
    .run     (run),
    .go      (go),
    .started (started)
  );

  // Code to millisecond conversion
  always_comb begin
    dly_ms[RAIL_SRC]  = K_LONG * CNT_W'(src_dly_code);
    dly_ms[RAIL_GH]   = K_LONG * CNT_W'(gh_dly_code);
    dly_ms[RAIL_GL]   = K_LONG * CNT_W'(gl_dly_code);
    dly_ms[RAIL_CORE] = K_BUCK * CNT_W'(core_dly_code);
    dly_ms[RAIL_IO]   = K_BUCK * CNT_W'(io_dly_code);
    dly_ms[RAIL_LIN]  = K_BUCK * CNT_W'(lin_dly_code);
    dly_ms[RAIL_COM]  = K_LONG * CNT_W'(com_dly_code);
    ss_ms[RAIL_SRC]   = K_SRCSS * (CNT_W'(src_ss_code) + ONE);
    ss_ms[RAIL_GH]    = K_GATSS * (CNT_W'(gh_ss_code) + ONE);
    ss_ms[RAIL_GL]    = K_GATSS * (CNT_W'(gl_ss_code) + ONE);
    ss_ms[RAIL_CORE]  = K_FIXSS;
    ss_ms[RAIL_IO]    = K_FIXSS;
    ss_ms[RAIL_LIN]   = K_FIXSS;
    ss_ms[RAIL_COM]   = K_FIXSS;
  end

  // Head of the chain: main boost, started by the run start event
  pwrseq_rail_timer #(.CNT_W(CNT_W)) u_src (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .trig    (go),
    .tick    (tick_ms),
    .dly_ms  (dly_ms[RAIL_SRC]),
    .ss_ms   (ss_ms[RAIL_SRC]),
    .ramp_o  (ramp_vec[RAIL_SRC]),
    .on_o    (on_vec[RAIL_SRC]),
    .start_p (src_start),
    .ready_p (src_ready)
  );
  assign start_vec[RAIL_SRC] = src_start;
  assign ready_vec[RAIL_SRC] = src_ready;

  // Dependent rails, trigger chosen per rail
  for (genvar g = 1; g < NRAIL; g++) begin : g_dep
    logic trig_g;
    if (trig_of(g) == TRG_SRC_READY) begin : g_rdy
      assign trig_g = src_ready;
    end else if (trig_of(g) == TRG_SRC_RAMP) begin : g_rmp
      assign trig_g = src_start;
    end else begin : g_go
      assign trig_g = go;
    end
    pwrseq_rail_timer #(.CNT_W(CNT_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (run),
      .trig    (trig_g),
      .tick    (tick_ms),
      .dly_ms  (dly_ms[g]),
      .ss_ms   (ss_ms[g]),
      .ramp_o  (ramp_vec[g]),
      .on_o    (on_vec[g]),
      .start_p (start_vec[g]),
      .ready_p (ready_vec[g])
    );
  end

  pwrseq_done_mon #(.N(NRAIL)) u_done (
    .started  (started),
    .on_vec   (on_vec),
    .ready_in (rail_ready),
    .mask     (rail_mask),
    .done     (seq_done)
  );

  assign rail_en = {NRAIL{run}} & rail_mask & (ramp_vec | on_vec);
  assign rail_ss = {NRAIL{run}} & rail_mask & ramp_vec;

  // R7: gate-high is never active before the main boost is ready
  p_gh_after_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_vec[RAIL_GH] | on_vec[RAIL_GH]) |-> on_vec[RAIL_SRC]);

  // R5 and R6: gate-low and common amplifier follow the main ramp start
  p_gl_com_after_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ramp_vec[RAIL_GL] | on_vec[RAIL_GL] | ramp_vec[RAIL_COM] | on_vec[RAIL_COM])
      |-> (ramp_vec[RAIL_SRC] | on_vec[RAIL_SRC]));

  // R11: done implies every enabled rail is up and none is ramping
  p_done_all_up_r11: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> ((rail_en == rail_mask) && (rail_ss == '0)));

  // R8: a start pulse always lands in the ramp state
  p_start_lands_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_vec != '0) |=> ((ramp_vec & $past(start_vec)) == $past(start_vec)));

  // R3: a ready pulse always lands in the on state
  p_ready_lands_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ready_vec != '0) |=> ((on_vec & $past(ready_vec)) == $past(ready_vec)));

endmodule

// File: tb/tb_power_seq_ctrl.sv
`timescale 1ns/1ps
module tb_power_seq_ctrl;

  localparam int N      = 7;
  localparam int FIX_SS = 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_ms = 1'b0;
  logic uvlo_ok = 1'b0;
  logic en = 1'b0;
  logic [N-1:0] rail_mask = '1;
  logic [N-1:0] hold_low = '0;
  logic [N-1:0] rail_ready;
  logic [2:0] src_dly_code = 3'd2, gh_dly_code = 3'd4, gl_dly_code = 3'd2;
  logic [1:0] src_ss_code = 2'd0, gh_ss_code = 2'd0, gl_ss_code = 2'd1;
  logic [1:0] core_dly_code = 2'd1, io_dly_code = 2'd1, lin_dly_code = 2'd1;
  logic [4:0] com_dly_code = 5'd5;
  logic [N-1:0] rail_en, rail_ss;
  logic seq_done;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit cmp_on = 0;

  // Model state
  bit m_active = 0;
  int m_t = 0;
  logic [N-1:0] m_en, m_ss;
  logic m_done;

  always #2 clk = ~clk;

  assign rail_ready = rail_en & ~hold_low;

  power_seq_ctrl dut (
    .clk(clk), .rst_n(rst_n), .tick_ms(tick_ms), .uvlo_ok(uvlo_ok), .en(en),
    .rail_mask(rail_mask), .rail_ready(rail_ready),
    .src_dly_code(src_dly_code), .src_ss_code(src_ss_code),
    .gh_dly_code(gh_dly_code), .gh_ss_code(gh_ss_code),
    .gl_dly_code(gl_dly_code), .gl_ss_code(gl_ss_code),
    .core_dly_code(core_dly_code), .io_dly_code(io_dly_code),
    .lin_dly_code(lin_dly_code), .com_dly_code(com_dly_code),
    .rail_en(rail_en), .rail_ss(rail_ss), .seq_done(seq_done)
  );

  function automatic string tag_of(input int i);
    case (i)
      0: return "R3";
      1: return "R7";
      2: return "R5";
      6: return "R6";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Tick source: one pulse every third cycle, driven after the edge
  initial begin
    int c = 0;
    forever begin
      @(posedge clk); #1;
      c++;
      tick_ms = (c % 3 == 0);
    end
  end

  // Reference model: elapsed ticks since the start event
  initial begin
    forever begin
      @(posedge clk);
      if (!rst_n || !(uvlo_ok && en)) m_active = 0;
      else if (!m_active) begin m_active = 1; m_t = 0; end
      else if (tick_ms) m_t++;
    end
  end

  // Compare every cycle away from the edge
  initial begin
    forever begin
      @(negedge clk);
      begin
        int rs[N];
        int ont[N];
        bit run_now;
        rs[0] = 5 * src_dly_code;  ont[0] = rs[0] + 5 * (src_ss_code + 1);
        rs[3] = 3 * core_dly_code; ont[3] = rs[3] + FIX_SS;
        rs[4] = 3 * io_dly_code;   ont[4] = rs[4] + FIX_SS;
        rs[5] = 3 * lin_dly_code;  ont[5] = rs[5] + FIX_SS;
        rs[2] = rs[0] + 5 * gl_dly_code;  ont[2] = rs[2] + 2 * (gl_ss_code + 1);
        rs[6] = rs[0] + 5 * com_dly_code; ont[6] = rs[6] + FIX_SS;
        rs[1] = ont[0] + 5 * gh_dly_code; ont[1] = rs[1] + 2 * (gh_ss_code + 1);
        run_now = uvlo_ok && en && m_active;
        m_done = run_now;
        for (int i = 0; i < N; i++) begin
          m_en[i] = run_now && rail_mask[i] && (m_t >= rs[i]);
          m_ss[i] = m_en[i] && (m_t < ont[i]);
          if (rail_mask[i] && !((m_t >= ont[i]) && m_en[i] && !hold_low[i])) m_done = 0;
        end
        if (cmp_on) begin
          int bad;
          bad = -1;
          for (int i = N - 1; i >= 0; i--) if (rail_en[i] !== m_en[i] || rail_ss[i] !== m_ss[i]) bad = i;
          chk(rail_en === m_en, (bad >= 0) ? tag_of(bad) : "R3", 32'(rail_en), 32'(m_en));
          chk(rail_ss === m_ss, (bad >= 0) ? tag_of(bad) : "R3", 32'(rail_ss), 32'(m_ss));
          chk(seq_done === m_done, "R11", 32'(seq_done), 32'(m_done));
        end
      end
    end
  end

  task automatic at_edge();
    @(posedge clk); #1;
  endtask

  task automatic run_until_done(input int limit);
    int k = 0;
    while (!m_done && k < limit) begin @(posedge clk); k++; end
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic finish_up();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=running expected=finished");
    finish_up();
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(rail_en == 0 && rail_ss == 0 && seq_done == 0, "R1", 32'({rail_en, rail_ss, seq_done}), 0);
    at_edge(); rst_n = 1'b1;
    cmp_on = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(rail_en == 0 && seq_done == 0, "R1", 32'({rail_en, seq_done}), 0);

    // R2: one flag alone starts nothing
    at_edge(); uvlo_ok = 1'b1; en = 1'b0;
    repeat (20) @(posedge clk); @(negedge clk);
    chk(rail_en == 0, "R2", 32'(rail_en), 0);
    at_edge(); uvlo_ok = 1'b0; en = 1'b1;
    repeat (20) @(posedge clk); @(negedge clk);
    chk(rail_en == 0, "R2", 32'(rail_en), 0);

    // Default codes, full sequence
    at_edge(); uvlo_ok = 1'b1;
    run_until_done(3000);
    chk(seq_done == 1'b1, "R11", 32'(seq_done), 1);
    chk(rail_en == 7'h7F && rail_ss == 0, "R3", 32'(rail_en), 32'h7F);

    // R9: lockout drop clears everything in the same cycle
    at_edge(); uvlo_ok = 1'b0;
    @(negedge clk);
    chk(rail_en == 0 && rail_ss == 0 && seq_done == 0, "R9", 32'({rail_en, rail_ss, seq_done}), 0);

    // Mixed codes, stop by enable in mid-sequence, then restart
    src_dly_code = 3'd1; src_ss_code = 2'd2; gh_dly_code = 3'd0; gh_ss_code = 2'd3;
    gl_dly_code = 3'd3; gl_ss_code = 2'd0; core_dly_code = 2'd2; io_dly_code = 2'd0;
    lin_dly_code = 2'd3; com_dly_code = 5'd2;
    repeat (3) at_edge();
    uvlo_ok = 1'b1;
    repeat (40) @(posedge clk);
    #1; en = 1'b0;
    @(negedge clk);
    chk(rail_en == 0 && rail_ss == 0, "R9", 32'({rail_en, rail_ss}), 0);
    repeat (5) at_edge();
    en = 1'b1;
    @(negedge clk);
    chk(rail_en == 0, "R9", 32'(rail_en), 0);
    run_until_done(3000);
    chk(seq_done == 1'b1, "R7", 32'(seq_done), 1);

    // R8: all-zero codes start in the trigger cycle
    at_edge(); en = 1'b0;
    src_dly_code = 0; src_ss_code = 0; gh_dly_code = 0; gh_ss_code = 0;
    gl_dly_code = 0; gl_ss_code = 0; core_dly_code = 0; io_dly_code = 0;
    lin_dly_code = 0; com_dly_code = 0;
    repeat (3) at_edge();
    en = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(rail_ss == 7'b1111101, "R8", 32'(rail_ss), 32'h7D);
    run_until_done(3000);
    chk(seq_done == 1'b1, "R8", 32'(seq_done), 1);

    // Maximum codes
    at_edge(); en = 1'b0;
    src_dly_code = 7; src_ss_code = 3; gh_dly_code = 7; gh_ss_code = 3;
    gl_dly_code = 7; gl_ss_code = 3; core_dly_code = 3; io_dly_code = 3;
    lin_dly_code = 3; com_dly_code = 31;
    repeat (3) at_edge();
    en = 1'b1;
    run_until_done(5000);
    chk(seq_done == 1'b1, "R6", 32'(seq_done), 1);

    // R10: main boost disabled but still paces its dependants
    at_edge(); en = 1'b0;
    src_dly_code = 3'd2; src_ss_code = 2'd0; gh_dly_code = 3'd4; gh_ss_code = 2'd0;
    gl_dly_code = 3'd2; gl_ss_code = 2'd1; core_dly_code = 2'd1; io_dly_code = 2'd1;
    lin_dly_code = 2'd1; com_dly_code = 5'd5;
    rail_mask = 7'b1111110;
    repeat (3) at_edge();
    en = 1'b1;
    run_until_done(3000);
    chk(rail_en == 7'b1111110 && seq_done == 1'b1, "R10", 32'({rail_en, seq_done}), 32'hFD);

    // R11: a held-low ready keeps done low
    at_edge(); en = 1'b0;
    rail_mask = '1; hold_low = 7'b0001000;
    repeat (3) at_edge();
    en = 1'b1;
    repeat (600) @(posedge clk);
    @(negedge clk);
    chk(seq_done == 1'b0 && rail_en == 7'h7F, "R11", 32'({rail_en, seq_done}), 32'hFE);
    at_edge(); hold_low = '0;
    @(negedge clk);
    chk(seq_done == 1'b1, "R11", 32'(seq_done), 1);

    repeat (4) @(posedge clk);
    finish_up();
  end

endmodule